// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner

This block is the front end between the raw clock and data lines of a two-wire serial bus and a slave protocol engine running on the system clock. Each line is passed through a multi-flop synchroniser and then through a spike filter. The filter accepts a new level only after the line has held it for a set number of system clocks. From the cleaned lines the block derives single-cycle pulses for clock rising and falling edges and for start and stop conditions. It also produces a data bit sampled on each clock rising edge and a busy flag that spans the time from a start to a stop.

On the transmit side the engine raises a request to pull the data line low. The block forwards this request to the pad's drive-low enable only while the filtered clock is low and a hold window has elapsed since the last clock falling edge. The window is a parameter counted in system clocks. A slave transmitter built on this block therefore never moves the data line while the clock is high or inside the undefined region just after the falling edge, and so cannot create a false start or stop.

Top module: `twl_line_cond`

## Requirements
- R1: A level change on either input line that is held for at least FILT_LEN clocks appears on the matching level output (`scl_lvl` or `sda_lvl`) exactly SYNC_STAGES + FILT_LEN clock edges after the first edge that samples it.
- R2: A pulse on either line that lasts fewer than FILT_LEN clocks leaves the level outputs unchanged and produces no edge, start or stop pulse. A pulse of exactly FILT_LEN clocks is accepted.
- R3: When the data line goes from high to low while the clock line is high, `start_evt` is 1 for exactly one cycle. This includes a repeated start during a transfer.
- R4: When the data line goes from low to high while the clock line is high, `stop_evt` is 1 for exactly one cycle.
- R5: Every accepted clock rising edge gives exactly one one-cycle `scl_rise` pulse, and every accepted clock falling edge gives exactly one one-cycle `scl_fall` pulse. A data line change while the clock is low gives no pulse. At most one of the four event pulses is 1 in any cycle.
- R6: `bit_stb` is 1 for one cycle at each clock rising edge. In that same cycle `rx_bit` shows the filtered data level at the edge (1 = line high), and `rx_bit` changes in no other cycle.
- R7: `busy` is 1 from the cycle of a start pulse until the cycle of a stop pulse. A repeated start leaves it at 1, and it goes high only together with a start pulse.
- R8: `sda_drive_low` never changes while `scl_lvl` is 1. A request that changes while the clock is high takes no effect until the clock is low.
- R9: A pending change of `sda_low_req` reaches `sda_drive_low` no earlier than HOLD_LEN + 1 clock edges after the edge at which `scl_lvl` falls, and exactly then if it was pending from before the fall. Once that window has passed and the clock stays low, the output follows the request on the next clock edge.
- R10: During and right after reset, `scl_lvl`, `sda_lvl` and `rx_bit` are 1, `busy` and `sda_drive_low` are 0, and no event pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line from the pad |
| sda_in | input | 1 | Raw bus data line from the pad |
| sda_low_req | input | 1 | Engine request to pull the data line low |
| scl_lvl | output | 1 | Filtered clock level, aligned with the event pulses |
| sda_lvl | output | 1 | Filtered data level, aligned with the event pulses |
| scl_rise | output | 1 | One-cycle pulse on a clock rising edge |
| scl_fall | output | 1 | One-cycle pulse on a clock falling edge |
| start_evt | output | 1 | One-cycle pulse on a start condition |
| stop_evt | output | 1 | One-cycle pulse on a stop condition |
| bit_stb | output | 1 | One-cycle strobe marking a newly sampled data bit |
| rx_bit | output | 1 | Data bit sampled at the last clock rising edge |
| busy | output | 1 | Bus held between a start and a stop |
| sda_drive_low | output | 1 | Enable for the pad's open-drain pull-down |

## Verification
The bench builds the block with SYNC_STAGES = 2, FILT_LEN = 3 and HOLD_LEN = 5. With the short filter, two-cycle and three-cycle pulses sit on either side of the acceptance limit. This makes the rejection boundary and the exact level latency visible at single-cycle resolution. With the short hold window, the one clock edge at which a pending drive change must land can be probed from both sides within about a dozen cycles. The larger defaults leave this logic unchanged and only widen its counters.

// File: rtl/twl_pkg.sv
package twl_pkg;

   // Bus events derived from the filtered lines
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } twl_evt_t;

   // Counter width able to hold the value n
   function automatic int cnt_w(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/twl_glitch_filt.sv
module twl_glitch_filt #(
   parameter int LEN     = 3,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (LEN == 0) begin : g_bypass
         assign q = d;
      end else begin : g_count
         localparam int CW = twl_pkg::cnt_w(LEN);
         logic [CW-1:0] run;
         logic          q_r;

         // The output takes the new level after LEN differing samples in a row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run <= '0;
               q_r <= RST_VAL;
            end else if (d == q_r) begin
               run <= '0;
            end else if (run == CW'(LEN - 1)) begin
               run <= '0;
               q_r <= d;
            end else begin
               run <= run + 1'b1;
            end
         end

         assign q = q_r;
      end
   endgenerate

endmodule

// File: rtl/twl_evt_det.sv
module twl_evt_det (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_f,
   input  logic               sda_f,
   output twl_pkg::twl_evt_t  evt,
   output logic               scl_lvl,
   output logic               sda_lvl,
   output logic               bit_stb,
   output logic               rx_bit,
   output logic               busy
);

   import twl_pkg::*;

   logic     scl_p, sda_p;
   twl_evt_t evt_c, evt_q;
   logic     stb_q, bit_q, busy_q;

   always_comb begin
      evt_c.rise  = scl_f & ~scl_p;
      evt_c.fall  = ~scl_f & scl_p;
      evt_c.start = scl_f & scl_p & sda_p & ~sda_f;
      evt_c.stop  = scl_f & scl_p & ~sda_p & sda_f;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
         evt_q  <= '0;
         stb_q  <= 1'b0;
         bit_q  <= 1'b1;
         busy_q <= 1'b0;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
         evt_q <= evt_c;
         stb_q <= evt_c.rise;
         if (evt_c.rise) begin
            bit_q <= sda_f;
         end
         if (evt_c.start) begin
            busy_q <= 1'b1;
         end else if (evt_c.stop) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign evt     = evt_q;
   assign scl_lvl = scl_p;
   assign sda_lvl = sda_p;
   assign bit_stb = stb_q;
   assign rx_bit  = bit_q;
   assign busy    = busy_q;

endmodule

// File: rtl/twl_tx_hold.sv
module twl_tx_hold #(
   parameter int HOLD_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic req,
   output logic drv
);

   logic scl_d;
   logic drv_q;
   logic fall_c;
   logic win_open;

   assign fall_c = scl_d & ~scl_f;

   generate
      if (HOLD_LEN == 0) begin : g_no_wait
         assign win_open = 1'b1;
      end else begin : g_wait
         localparam int CW = twl_pkg::cnt_w(HOLD_LEN);
         logic [CW-1:0] left;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left <= '0;
            end else if (fall_c) begin
               left <= CW'(HOLD_LEN);
            end else if (left != '0) begin
               left <= left - 1'b1;
            end
         end

         assign win_open = (left == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         drv_q <= 1'b0;
      end else begin
         scl_d <= scl_f;
         if (!scl_f && !fall_c && win_open) begin
            drv_q <= req;
         end
      end
   end

   assign drv = drv_q;

endmodule

// File: rtl/twl_line_cond.sv
module twl_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 13,
   parameter int HOLD_LEN    = 75
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic sda_low_req,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt,
   output logic bit_stb,
   output logic rx_bit,
   output logic busy,
   output logic sda_drive_low
);

   import twl_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twl_line_cond: SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 0) begin : g_bad_filt
         $error("twl_line_cond: FILT_LEN must not be negative");
      end
      if (HOLD_LEN < 0) begin : g_bad_hold
         $error("twl_line_cond: HOLD_LEN must not be negative");
      end
   endgenerate

   logic [1:0] raw_w, sync_w, filt_w;
   twl_evt_t   evt;

   assign raw_w = {scl_in, sda_in};

   // Index 1 carries the clock line, index 0 the data line
   generate
      for (genvar i = 0; i < 2; i++) begin : g_line
         twl_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_w[i]),
            .q     (sync_w[i])
         );

         twl_glitch_filt #(
            .LEN     (FILT_LEN),
            .RST_VAL (1'b1)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (sync_w[i]),
            .q     (filt_w[i])
         );
      end
   endgenerate

   twl_evt_det u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (filt_w[1]),
      .sda_f   (filt_w[0]),
      .evt     (evt),
      .scl_lvl (scl_lvl),
      .sda_lvl (sda_lvl),
      .bit_stb (bit_stb),
      .rx_bit  (rx_bit),
      .busy    (busy)
   );

   twl_tx_hold #(
      .HOLD_LEN (HOLD_LEN)
   ) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_f (filt_w[1]),
      .req   (sda_low_req),
      .drv   (sda_drive_low)
   );

   assign scl_rise  = evt.rise;
   assign scl_fall  = evt.fall;
   assign start_evt = evt.start;
   assign stop_evt  = evt.stop;

endmodule

// File: rtl/twl_line_cond_chk.sv
module twl_line_cond_chk #(
   parameter int HOLD_LEN = 75
) (
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic sda_lvl,
   input logic scl_rise,
   input logic scl_fall,
   input logic start_evt,
   input logic stop_evt,
   input logic bit_stb,
   input logic rx_bit,
   input logic busy,
   input logic sda_drive_low
);

   localparam int SAT = HOLD_LEN + 1;
   localparam int CW  = twl_pkg::cnt_w(SAT);

   // Counts cycles the filtered clock has stayed low, saturating at SAT
   logic [CW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
      end else if (scl_lvl) begin
         low_run <= '0;
      end else if (low_run != CW'(SAT)) begin
         low_run <= low_run + 1'b1;
      end
   end

   AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));  // R5

   AST_RISE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |-> (scl_lvl && !$past(scl_lvl)));  // R5

   AST_START_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |-> (scl_lvl && $past(scl_lvl) && !sda_lvl && $past(sda_lvl)));  // R3

   AST_STOP_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |-> (scl_lvl && $past(scl_lvl) && sda_lvl && !$past(sda_lvl)));  // R4

   AST_BIT_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_bit) |-> bit_stb);  // R6

   AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |-> busy);  // R7

   AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |-> !busy);  // R7

   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> start_evt);  // R7

   AST_DRV_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> !scl_lvl);  // R8

   AST_HOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> (low_run >= CW'(SAT)));  // R9

endmodule

bind twl_line_cond twl_line_cond_chk #(
   .HOLD_LEN (HOLD_LEN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_lvl       (scl_lvl),
   .sda_lvl       (sda_lvl),
   .scl_rise      (scl_rise),
   .scl_fall      (scl_fall),
   .start_evt     (start_evt),
   .stop_evt      (stop_evt),
   .bit_stb       (bit_stb),
   .rx_bit        (rx_bit),
   .busy          (busy),
   .sda_drive_low (sda_drive_low)
);

// File: tb/twl_line_cond_test.sv
module twl_line_cond_test;

   localparam int S = 2;
   localparam int L = 3;
   localparam int H = 5;
   localparam int SEG = 12;
   localparam int NV = 17;

   // Vector fields: [8] clock line, [7] data line, [6] starts, [5] stops,
   // [4] rises, [3] falls, [2] busy after, [1] check bit, [0] expected bit
   localparam logic [8:0] VEC [NV] = '{
      9'b11_0000_0_00,  // idle
      9'b10_1000_1_00,  // start
      9'b00_0001_1_00,  // clock falls
      9'b01_0000_1_00,  // data changes while clock low
      9'b11_0010_1_11,  // rise, bit 1
      9'b01_0001_1_00,  // fall
      9'b00_0000_1_00,  // data to 0 while low
      9'b10_0010_1_10,  // rise, bit 0
      9'b11_0100_0_00,  // stop
      9'b10_1000_1_00,  // start
      9'b00_0001_1_00,  // fall
      9'b01_0000_1_00,  // data to 1 while low
      9'b11_0010_1_11,  // rise, bit 1
      9'b10_1000_1_00,  // repeated start
      9'b00_0001_1_00,  // fall
      9'b10_0010_1_10,  // rise, bit 0
      9'b11_0100_0_00   // stop
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_r = 1'b1;
   logic sda_r = 1'b1;
   logic req_r = 1'b0;

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
   logic bit_stb, rx_bit, busy, sda_drive_low;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0, n_stb = 0;

   always #2 clk = ~clk;

   twl_line_cond #(
      .SYNC_STAGES (S),
      .FILT_LEN    (L),
      .HOLD_LEN    (H)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_in        (scl_r),
      .sda_in        (sda_r),
      .sda_low_req   (req_r),
      .scl_lvl       (scl_lvl),
      .sda_lvl       (sda_lvl),
      .scl_rise      (scl_rise),
      .scl_fall      (scl_fall),
      .start_evt     (start_evt),
      .stop_evt      (stop_evt),
      .bit_stb       (bit_stb),
      .rx_bit        (rx_bit),
      .busy          (busy),
      .sda_drive_low (sda_drive_low)
   );

   // Pulse-cycle counters; a pulse longer than one cycle counts more than once
   always @(posedge clk) begin
      if (start_evt) n_start <= n_start + 1;
      if (stop_evt)  n_stop  <= n_stop + 1;
      if (scl_rise)  n_rise  <= n_rise + 1;
      if (scl_fall)  n_fall  <= n_fall + 1;
      if (bit_stb)   n_stb   <= n_stb + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int s0, p0, r0, f0, b0;

      // R10: reset state
      wait_cyc(3);
      chk("R10 scl_lvl in reset", scl_lvl, 1);
      chk("R10 sda_lvl in reset", sda_lvl, 1);
      chk("R10 rx_bit in reset", rx_bit, 1);
      chk("R10 busy in reset", busy, 0);
      chk("R10 drive in reset", sda_drive_low, 0);
      chk("R10 pulses in reset",
          {start_evt, stop_evt, scl_rise, scl_fall, bit_stb}, 0);
      rst_n = 1'b1;
      wait_cyc(SEG);
      chk("R10 busy after reset", busy, 0);
      chk("R10 no pulses after reset", n_start + n_stop + n_rise + n_fall, 0);

      // Table walk: R3 R4 R5 R6 R7
      for (int v = 0; v < NV; v++) begin
         s0 = n_start; p0 = n_stop; r0 = n_rise; f0 = n_fall; b0 = n_stb;
         scl_r = VEC[v][8];
         sda_r = VEC[v][7];
         wait_cyc(SEG);
         chk($sformatf("R3 start count v%0d", v), n_start - s0, int'(VEC[v][6]));
         chk($sformatf("R4 stop count v%0d", v), n_stop - p0, int'(VEC[v][5]));
         chk($sformatf("R5 rise count v%0d", v), n_rise - r0, int'(VEC[v][4]));
         chk($sformatf("R5 fall count v%0d", v), n_fall - f0, int'(VEC[v][3]));
         chk($sformatf("R6 strobe count v%0d", v), n_stb - b0, int'(VEC[v][4]));
         chk($sformatf("R7 busy v%0d", v), busy, int'(VEC[v][2]));
         if (VEC[v][1]) begin
            chk($sformatf("R6 rx_bit v%0d", v), rx_bit, int'(VEC[v][0]));
         end
      end

      // R1: latency of an accepted data line change (a start here)
      sda_r = 1'b0;
      repeat (S + L) @(posedge clk);
      @(negedge clk);
      chk("R1 sda_lvl one edge early", sda_lvl, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R1 sda_lvl at latency", sda_lvl, 0);
      chk("R3 start aligned with level", start_evt, 1);
      sda_r = 1'b1;
      wait_cyc(SEG);
      chk("R7 idle after stop", busy, 0);

      // R2: clock pulse one cycle short of the filter length
      r0 = n_rise; f0 = n_fall;
      scl_r = 1'b0;
      wait_cyc(L - 1);
      scl_r = 1'b1;
      wait_cyc(SEG);
      chk("R2 short clock pulse no edges", (n_rise - r0) + (n_fall - f0), 0);
      chk("R2 short clock pulse level", scl_lvl, 1);

      // R2: short data pulse while clock high makes no start
      s0 = n_start; p0 = n_stop;
      sda_r = 1'b0;
      wait_cyc(L - 1);
      sda_r = 1'b1;
      wait_cyc(SEG);
      chk("R2 short data pulse no start/stop", (n_start - s0) + (n_stop - p0), 0);
      chk("R2 short data pulse busy", busy, 0);

      // R2: pulse of exactly the filter length is accepted
      s0 = n_start; p0 = n_stop;
      sda_r = 1'b0;
      wait_cyc(L);
      sda_r = 1'b1;
      wait_cyc(SEG);
      chk("R2 boundary pulse start", n_start - s0, 1);
      chk("R2 boundary pulse stop", n_stop - p0, 1);

      // R8: request while clock high is not forwarded
      req_r = 1'b1;
      wait_cyc(SEG);
      chk("R8 no drive while clock high", sda_drive_low, 0);

      // R9: pending request lands HOLD_LEN+1 edges after scl_lvl falls
      scl_r = 1'b0;
      repeat (S + L + 1 + H) @(posedge clk);
      @(negedge clk);
      chk("R9 drive not before window", sda_drive_low, 0);
      chk("R5 fall seen before window end", scl_lvl, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R9 drive at window end", sda_drive_low, 1);

      // R9: window elapsed, output follows on next edge
      req_r = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R9 follow next edge", sda_drive_low, 0);

      // R8: clock back high, request changes are held off
      scl_r = 1'b1;
      wait_cyc(SEG);
      req_r = 1'b1;
      wait_cyc(SEG);
      chk("R8 held while clock high again", sda_drive_low, 0);
      req_r = 1'b0;
      wait_cyc(4);
      chk("R8 drive still low-off", sda_drive_low, 0);

      finish_run();
   end

endmodule